// File: doc/BRIEF.md
# Filter Search Limit Tracker

This block keeps, for every kind of packet filter held in a hashed filter table, the deepest probe count that any successful insert has needed so far. The lookup logic must search at least that far before giving up, so the block turns each tracked depth into a search-limit value and drives it on a port. A pipeline offset is added to each limit. Exact-match kinds get a small offset and wildcard kinds a larger one. The sum saturates at the top of the limit field.

The table engine reports two kinds of event. The first is a finished insert, which carries the filter kind and the probe depth it took. The second is a per-group "table now empty" pulse. A depth only ever grows. It returns to zero only when its whole table group empties. Whenever a limit output changes, a one-cycle strobe is raised for the receive side or the transmit side, so that the matching limit register can be rewritten. MAC kinds whose table is built with zero rows carry no state, and their limits stay at zero.

Top module: `search_limit_tracker`

## Requirements
- R1: After reset every tracked depth is zero, so each exact-kind limit reads 1, each wildcard-kind limit reads 3, and both strobes are low.
- R2: An insert (`ins_valid_i` high) whose depth is larger than the stored depth of its kind raises that kind's limit to the new depth plus offset, on the cycle after the event.
- R3: An insert whose depth is equal to or less than the stored depth leaves every limit unchanged and raises no strobe.
- R4: Kind codes on `ins_type_i` are as follows. The receive side uses 0 TCP exact, 1 TCP wildcard, 2 UDP exact, 3 UDP wildcard, 4 MAC exact and 5 MAC wildcard. Codes 6 to 11 are the same six kinds for the transmit side. Even codes are exact and add 1; odd codes are wildcard and add 3. Kind k drives `limit_o[k*LIM_W +: LIM_W]`.
- R5: When depth plus offset exceeds the limit field, the limit saturates at 2^LIM_W-1.
- R6: `rx_update_o` is high for exactly the cycles in which any of limits 0 to 5 differs from its value on the previous cycle. `tx_update_o` does the same for limits 6 to 11.
- R7: `grp_empty_i` has one bit per group. Bit 0 is receive IP (kinds 0-3), bit 1 is receive MAC (kinds 4-5), bit 2 is transmit IP (kinds 6-9) and bit 3 is transmit MAC (kinds 10-11). A set bit returns the depths of its group to zero on the next cycle. An insert to that group in the same cycle is dropped, and other groups are not touched.
- R8: When `RX_MAC_ROWS` or `TX_MAC_ROWS` is zero, the MAC-kind limits on that side read zero at all times and never cause a strobe.
- R9: Kind codes 12 to 15 are ignored.
- R10: Apart from a group clear, no limit ever decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | Insert-complete event |
| ins_type_i | input | 4 | Filter kind code of the insert |
| ins_depth_i | input | DEPTH_W | Probe depth the insert needed |
| grp_empty_i | input | 4 | Per-group table-empty pulses |
| limit_o | output | 12*LIM_W | Registered search limits, one field per kind |
| rx_update_o | output | 1 | A receive limit changed this cycle |
| tx_update_o | output | 1 | A transmit limit changed this cycle |

## Verification
A depth register that holds a wrong value shows up on its limit field on the very next cycle. A mixed-up offset or kind decode shows up as a field that is off by two or that sits in the wrong slot, also on the next cycle. A missed or spurious strobe is seen in the same cycle as the limit change it should have followed. A group clear that misses or over-reaches leaves non-zero or zeroed fields one cycle after the empty pulse. For these reasons the bench compares every field and both strobes after each event against a reference depth array. A second instance, built with no MAC tables, exposes any MAC state that should not exist.

// File: rtl/slt_pkg.sv
package slt_pkg;
   localparam int NUM_TYPES  = 12;
   localparam int NUM_GROUPS = 4;
   localparam int TYPE_W     = 4;
   localparam int RX_TYPES   = 6;

   typedef enum logic [1:0] {
      GRP_RX_IP  = 2'd0,
      GRP_RX_MAC = 2'd1,
      GRP_TX_IP  = 2'd2,
      GRP_TX_MAC = 2'd3
   } slt_group_e;

   // odd kind codes are wildcard matches
   function automatic bit type_is_wild(input int t);
      return (t % 2) == 1;
   endfunction

   function automatic bit type_is_mac(input int t);
      return (t == 4) || (t == 5) || (t == 10) || (t == 11);
   endfunction

   function automatic bit type_is_rx(input int t);
      return t < RX_TYPES;
   endfunction

   function automatic int type_group(input int t);
      if (t < 4)       return int'(GRP_RX_IP);
      else if (t < 6)  return int'(GRP_RX_MAC);
      else if (t < 10) return int'(GRP_TX_IP);
      else             return int'(GRP_TX_MAC);
   endfunction
endpackage

// File: rtl/slt_event_decode.sv
module slt_event_decode
   import slt_pkg::*;
(
   input  logic                  ins_valid_i,
   input  logic [TYPE_W-1:0]     ins_type_i,
   input  logic [NUM_GROUPS-1:0] grp_empty_i,
   output logic [NUM_TYPES-1:0]  hit_o,
   output logic [NUM_TYPES-1:0]  clr_o
);
   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_kind
      localparam int GRP = type_group(t);
      // codes beyond the last kind match no slot (R9)
      assign hit_o[t] = ins_valid_i && (ins_type_i == TYPE_W'(t));
      assign clr_o[t] = grp_empty_i[GRP];
   end
endmodule

// File: rtl/slt_type_cell.sv
module slt_type_cell #(
   parameter int DEPTH_W = 8,
   parameter int LIM_W   = 8,
   parameter int OFFSET  = 1,
   parameter bit PRESENT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_i,
   input  logic [DEPTH_W-1:0] depth_i,
   input  logic               clr_i,
   output logic [LIM_W-1:0]   limit_o,
   output logic               chg_o
);
   localparam int SUM_W     = ((DEPTH_W > LIM_W) ? DEPTH_W : LIM_W) + 2;
   localparam int LIM_MAX_I = (1 << LIM_W) - 1;
   localparam int LIM_RST_I = (OFFSET > LIM_MAX_I) ? LIM_MAX_I : OFFSET;

   if (OFFSET < 0) begin : g_bad_offset
      $error("slt_type_cell: OFFSET must not be negative");
   end

   if (PRESENT) begin : g_track
      logic [DEPTH_W-1:0] depth_q, depth_n;
      logic [LIM_W-1:0]   lim_q, lim_n;
      logic [SUM_W-1:0]   sum;

      always_comb begin
         depth_n = depth_q;
         if (clr_i)
            depth_n = '0;
         else if (hit_i && (depth_i > depth_q))
            depth_n = depth_i;
         sum = SUM_W'(depth_n) + SUM_W'(OFFSET);
         if (sum > SUM_W'(LIM_MAX_I))
            lim_n = LIM_W'(LIM_MAX_I);
         else
            lim_n = sum[LIM_W-1:0];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            depth_q <= '0;
            lim_q   <= LIM_W'(LIM_RST_I);
         end else begin
            depth_q <= depth_n;
            lim_q   <= lim_n;
         end
      end

      assign limit_o = lim_q;
      assign chg_o   = (lim_n != lim_q);

      assert_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_i |=> (limit_o >= $past(limit_o)));
      assert_group_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i |=> (limit_o == LIM_W'(LIM_RST_I)));
      assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
         limit_o >= LIM_W'(LIM_RST_I));
   end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, hit_i, depth_i, clr_i};
      assign limit_o   = '0;
      assign chg_o     = 1'b0;
   end
endmodule

// File: rtl/search_limit_tracker.sv
module search_limit_tracker
   import slt_pkg::*;
#(
   parameter int DEPTH_W     = 8,
   parameter int LIM_W       = 8,
   parameter int EXACT_OFS   = 1,
   parameter int WILD_OFS    = 3,
   parameter int RX_MAC_ROWS = 512,
   parameter int TX_MAC_ROWS = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ins_valid_i,
   input  logic [TYPE_W-1:0]          ins_type_i,
   input  logic [DEPTH_W-1:0]         ins_depth_i,
   input  logic [NUM_GROUPS-1:0]      grp_empty_i,
   output logic [NUM_TYPES*LIM_W-1:0] limit_o,
   output logic                       rx_update_o,
   output logic                       tx_update_o
);
   localparam int RX_BITS = RX_TYPES * LIM_W;

   if (LIM_W < 2)              begin : g_chk_lim   $error("LIM_W too small");       end
   if (DEPTH_W < 1)            begin : g_chk_dep   $error("DEPTH_W too small");     end
   if (WILD_OFS < EXACT_OFS)   begin : g_chk_ofs   $error("wild offset below exact"); end
   if (RX_MAC_ROWS < 0 || TX_MAC_ROWS < 0) begin : g_chk_rows $error("negative rows"); end

   logic [NUM_TYPES-1:0] hit, clr, chg;

   slt_event_decode u_dec (
      .ins_valid_i (ins_valid_i),
      .ins_type_i  (ins_type_i),
      .grp_empty_i (grp_empty_i),
      .hit_o       (hit),
      .clr_o       (clr)
   );

   for (genvar t = 0; t < NUM_TYPES; t++) begin : g_cell
      localparam int OFS  = type_is_wild(t) ? WILD_OFS : EXACT_OFS;
      localparam bit PRES = !type_is_mac(t) ? 1'b1 :
                            (type_is_rx(t) ? (RX_MAC_ROWS != 0) : (TX_MAC_ROWS != 0));
      slt_type_cell #(
         .DEPTH_W (DEPTH_W),
         .LIM_W   (LIM_W),
         .OFFSET  (OFS),
         .PRESENT (PRES)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit_i   (hit[t]),
         .depth_i (ins_depth_i),
         .clr_i   (clr[t]),
         .limit_o (limit_o[t*LIM_W +: LIM_W]),
         .chg_o   (chg[t])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_update_o <= 1'b0;
         tx_update_o <= 1'b0;
      end else begin
         rx_update_o <= |chg[RX_TYPES-1:0];
         tx_update_o <= |chg[NUM_TYPES-1:RX_TYPES];
      end
   end

   assert_rx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_update_o == (limit_o[RX_BITS-1:0] != $past(limit_o[RX_BITS-1:0])));
   assert_tx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_update_o == (limit_o[NUM_TYPES*LIM_W-1:RX_BITS] != $past(limit_o[NUM_TYPES*LIM_W-1:RX_BITS])));
   assert_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_i && (ins_type_i >= TYPE_W'(NUM_TYPES)) && (grp_empty_i == '0)) |=> $stable(limit_o));
endmodule

// File: tb/sim_search_limit_tracker.sv
`timescale 1ns/1ps
module sim_search_limit_tracker;
   localparam int DW = 8;
   localparam int LW = 8;
   localparam int NT = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0;
   logic [3:0] ins_type = '0;
   logic [DW-1:0] ins_depth = '0;
   logic [3:0] grp_empty = '0;
   logic [NT*LW-1:0] lim0, lim1;
   logic rxu0, txu0, rxu1, txu1;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int exp_d [NT];

   always #4 clk = ~clk;

   search_limit_tracker #(.DEPTH_W(DW), .LIM_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid), .ins_type_i(ins_type),
      .ins_depth_i(ins_depth), .grp_empty_i(grp_empty), .limit_o(lim0),
      .rx_update_o(rxu0), .tx_update_o(txu0));

   // R8: same stimulus, built without MAC tables
   search_limit_tracker #(.DEPTH_W(DW), .LIM_W(LW), .RX_MAC_ROWS(0), .TX_MAC_ROWS(0)) u1 (
      .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid), .ins_type_i(ins_type),
      .ins_depth_i(ins_depth), .grp_empty_i(grp_empty), .limit_o(lim1),
      .rx_update_o(rxu1), .tx_update_o(txu1));

   function automatic bit is_mac(int t);
      return (t == 4) || (t == 5) || (t == 10) || (t == 11);
   endfunction

   function automatic int grp(int t);
      return (t < 4) ? 0 : (t < 6) ? 1 : (t < 10) ? 2 : 3;
   endfunction

   function automatic int exp_lim(int d, int t, bit present);
      int s;
      if (!present) return 0;
      s = d + (((t % 2) == 1) ? 3 : 1);
      return (s > 255) ? 255 : s;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag, bit rx0, bit tx0, bit rx1, bit tx1);
      for (int t = 0; t < NT; t++) begin
         chk(tag, $sformatf("u0 limit[%0d]", t), int'(lim0[t*LW +: LW]), exp_lim(exp_d[t], t, 1'b1));
         chk(tag, $sformatf("u1 limit[%0d]", t), int'(lim1[t*LW +: LW]), exp_lim(exp_d[t], t, !is_mac(t)));
      end
      chk(tag, "u0 rx_update", int'(rxu0), int'(rx0));
      chk(tag, "u0 tx_update", int'(txu0), int'(tx0));
      chk(tag, "u1 rx_update", int'(rxu1), int'(rx1));
      chk(tag, "u1 tx_update", int'(txu1), int'(tx1));
   endtask

   // drive one event at a falling edge, check one cycle later
   task automatic step(bit v, int typ, int dep, logic [3:0] emp, string tag);
      int old0 [NT];
      int old1 [NT];
      bit rx0 = 0, tx0 = 0, rx1 = 0, tx1 = 0;
      for (int t = 0; t < NT; t++) begin
         old0[t] = exp_lim(exp_d[t], t, 1'b1);
         old1[t] = exp_lim(exp_d[t], t, !is_mac(t));
      end
      for (int t = 0; t < NT; t++) begin
         if (emp[grp(t)]) exp_d[t] = 0;
         else if (v && typ == t && dep > exp_d[t]) exp_d[t] = dep;
      end
      for (int t = 0; t < NT; t++) begin
         if (exp_lim(exp_d[t], t, 1'b1) != old0[t]) begin
            if (t < 6) rx0 = 1; else tx0 = 1;
         end
         if (exp_lim(exp_d[t], t, !is_mac(t)) != old1[t]) begin
            if (t < 6) rx1 = 1; else tx1 = 1;
         end
      end
      ins_valid = v;
      ins_type  = 4'(typ);
      ins_depth = DW'(dep);
      grp_empty = emp;
      @(negedge clk);
      ins_valid = 1'b0;
      grp_empty = '0;
      check_all(tag, rx0, tx0, rx1, tx1);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd24681);
      for (int t = 0; t < NT; t++) exp_d[t] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);

      step(1, 0, 5, 4'b0000, "R2");      // rx tcp exact -> 6
      step(1, 1, 5, 4'b0000, "R4");      // rx tcp wild -> 8
      step(1, 0, 3, 4'b0000, "R3");      // smaller: no effect
      step(1, 0, 5, 4'b0000, "R3");      // equal: no effect
      step(0, 0, 0, 4'b0000, "R6");      // idle: strobes low
      step(1, 6, 7, 4'b0000, "R6");      // tx strobe only
      step(1, 13, 9, 4'b0000, "R9");     // unused code
      step(1, 15, 200, 4'b0000, "R9");
      step(1, 1, 255, 4'b0000, "R5");    // wild saturates
      step(1, 0, 254, 4'b0000, "R5");    // exact reaches max exactly
      step(1, 0, 255, 4'b0000, "R5");    // saturated, no change
      step(1, 4, 10, 4'b0000, "R8");     // mac kind: only u0 moves
      step(1, 11, 20, 4'b0000, "R8");
      step(1, 2, 9, 4'b0001, "R7");      // clear wins over insert
      step(1, 7, 30, 4'b0000, "R2");
      step(0, 0, 0, 4'b0100, "R7");      // clear tx ip only
      step(0, 0, 0, 4'b1010, "R7");      // clear both mac groups

      for (int i = 0; i < 400; i++) begin
         int typ, dep;
         logic [3:0] emp;
         typ = int'($urandom_range(0, 15));
         dep = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 20));
         emp = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(1, 15)) : 4'b0000;
         step($urandom_range(0, 3) != 0, typ, dep, emp, "R10");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule